// File: doc/BRIEF.md
# Multiply-Accumulate Accumulator Datapath

This block is the arithmetic core of a small 16-bit signal processor. It holds a 32-bit accumulator, two 16-bit multiplier operand registers X and Y, and a product P. The product is read-only and always equals twice X times Y. Instruction decode and operand fetch are done by the surrounding pipeline. Each cycle, that pipeline presents one 4-bit command code, a flag that selects whether the second operand is a 16-bit value or the 32-bit product, a 16-bit operand, and a pair of 16-bit multiplier operands.

When a 16-bit operand is used, arithmetic and logic work on the upper half of the accumulator. When the product is used, they work on all 32 bits. The fused multiply steps first consume the current product, then load a new X/Y pair, so the product always reflects the most recent pair. A 16-bit status word reports the zero and negative conditions of the result.

Every command completes in one clock. Unsupported codes do nothing except raise a one-cycle strobe.

Top module: `mac_acc_core`

## Requirements
- R1: While rst_ni is low, the accumulator, X, Y, the status word and illegal_o all read zero.
- R2: prod_o always equals the low 32 bits of 2*X*Y, with X and Y taken as unsigned numbers. It follows X and Y without any added cycle.
- R3: Add (op_i 4'h4) and subtract (op_i 4'h2) with src_p_i=0 change only accumulator bits 31:16, by plus or minus opnd_i. A carry or borrow out of bit 31 is dropped, and bits 15:0 keep their value.
- R4: With src_p_i=0, AND (4'h5) combines the accumulator with {opnd_i,16'h0}, which clears bits 15:0. OR (4'h6) and XOR (4'h7) combine opnd_i into bits 31:16 and leave bits 15:0 unchanged.
- R5: With src_p_i=1, add, subtract, AND, OR and XOR combine the full 32-bit accumulator with the product.
- R6: Compare (4'h3) never changes the accumulator. With src_p_i=0: Z is set when bits 31:16 equal opnd_i, and N takes bit 15 of (bits 31:16 minus opnd_i). With src_p_i=1: Z is set when the accumulator equals the product, and N takes bit 31 of (accumulator minus product).
- R7: Load (4'h1) with src_p_i=0 writes opnd_i into bits 31:16 and keeps bits 15:0. With src_p_i=1 it copies all 32 product bits. A load never changes the status word.
- R8: After add, subtract, AND, OR, XOR or a modifier, status bit 13 (Z) is 1 exactly when the 32-bit accumulator is zero. Status bit 15 (N) equals accumulator bit 31. All other status bits, including bits 12 and 14, read zero.
- R9: The modifiers act on the 32-bit accumulator and ignore src_p_i: 4'h8 is an arithmetic shift right by one, 4'h9 a shift left by one, 4'hA a two's-complement negate, and 4'hB an absolute value that negates only when bit 31 is set.
- R10: Multiply-load (4'hC) clears the accumulator and loads X from mul_a_i and Y from mul_b_i. The status word does not change.
- R11: Multiply-add (4'hD) and multiply-subtract (4'hE) add or subtract the product from before the edge, then load X and Y from mul_a_i and mul_b_i. The status word does not change.
- R12: Code 4'h0 changes nothing. Code 4'hF leaves the accumulator, X, Y and status unchanged and sets illegal_o high for exactly the following cycle. Every other code leaves illegal_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Command code |
| src_p_i | input | 1 | 1 selects the product as the operand, 0 selects opnd_i |
| opnd_i | input | 16 | 16-bit operand |
| mul_a_i | input | 16 | Next X value for the multiply steps |
| mul_b_i | input | 16 | Next Y value for the multiply steps |
| acc_o | output | 32 | Accumulator |
| x_o | output | 16 | X operand register |
| y_o | output | 16 | Y operand register |
| prod_o | output | 32 | Product, 2*X*Y |
| status_o | output | 16 | Status word: bit 15 N, bit 13 Z |
| illegal_o | output | 1 | Strobe for an unsupported command |

## Verification
The assertions check the following on every cycle:
- compare and load leave the accumulator or the flags alone, as the command requires;
- a flag-updating command leaves Z and N consistent with the new accumulator;
- multiply-load and multiply-add move the expected values into the accumulator and X/Y;
- the product changes only when X or Y changes;
- the unsupported-code strobe freezes state.

The exact arithmetic cannot be shown by those properties and is left to the bench's reference model. This covers the half-word alignment of 16-bit operands, the low-half clearing by AND, the absolute value of the most negative number, carry loss in the upper half, and the doubled product with large operands.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_LD   = 4'h1,
    OP_SUB  = 4'h2,
    OP_CMP  = 4'h3,
    OP_ADD  = 4'h4,
    OP_AND  = 4'h5,
    OP_OR   = 4'h6,
    OP_XOR  = 4'h7,
    OP_SHR  = 4'h8,
    OP_SHL  = 4'h9,
    OP_NEG  = 4'hA,
    OP_ABS  = 4'hB,
    OP_MLD  = 4'hC,
    OP_MPYA = 4'hD,
    OP_MPYS = 4'hE,
    OP_BAD  = 4'hF
  } mac_op_e;

  localparam int unsigned ST_W   = 16;
  localparam int unsigned ST_Z   = 13;
  localparam int unsigned ST_N   = 15;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int unsigned DW         = 16,
  parameter bit          SIGNED_MUL = 1'b0
) (
  input  logic [DW-1:0]   x_i,
  input  logic [DW-1:0]   y_i,
  output logic [2*DW-1:0] prod_o
);
  localparam int unsigned AW = 2 * DW;

  logic [AW-1:0] full;

  generate
    if (SIGNED_MUL) begin : g_signed
      assign full = AW'($signed(x_i) * $signed(y_i));
    end else begin : g_unsigned
      assign full = AW'(x_i) * AW'(y_i);
    end
  endgenerate

  // doubled product, top bit falls off
  assign prod_o = full << 1;
endmodule

// File: rtl/mac_alu.sv
module mac_alu
  import mac_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  mac_op_e         op_i,
  input  logic            src_p_i,
  input  logic [DW-1:0]   opnd_i,
  input  logic [2*DW-1:0] acc_i,
  input  logic [2*DW-1:0] prod_i,
  output logic [2*DW-1:0] acc_nx_o,
  output logic            acc_we_o,
  output logic            flag_we_o,
  output logic            xy_we_o,
  output logic            z_nx_o,
  output logic            n_nx_o,
  output logic            bad_o
);
  localparam int unsigned AW = 2 * DW;

  logic [AW-1:0] opw;
  logic [AW-1:0] cmp_w;
  logic [DW-1:0] cmp_h;

  // 16-bit operand aligned to the upper half; AND then clears the low half
  assign opw   = src_p_i ? prod_i : {opnd_i, {DW{1'b0}}};
  assign cmp_w = acc_i - prod_i;
  assign cmp_h = acc_i[AW-1:DW] - opnd_i;

  always_comb begin
    acc_nx_o  = acc_i;
    acc_we_o  = 1'b0;
    flag_we_o = 1'b0;
    xy_we_o   = 1'b0;
    bad_o     = 1'b0;
    case (op_i)
      OP_NOP: ;
      OP_LD: begin
        acc_we_o = 1'b1;
        acc_nx_o = src_p_i ? prod_i : {opnd_i, acc_i[DW-1:0]};
      end
      OP_ADD: begin acc_we_o = 1'b1; flag_we_o = 1'b1; acc_nx_o = acc_i + opw; end
      OP_SUB: begin acc_we_o = 1'b1; flag_we_o = 1'b1; acc_nx_o = acc_i - opw; end
      OP_AND: begin acc_we_o = 1'b1; flag_we_o = 1'b1; acc_nx_o = acc_i & opw; end
      OP_OR:  begin acc_we_o = 1'b1; flag_we_o = 1'b1; acc_nx_o = acc_i | opw; end
      OP_XOR: begin acc_we_o = 1'b1; flag_we_o = 1'b1; acc_nx_o = acc_i ^ opw; end
      OP_CMP: flag_we_o = 1'b1;
      OP_SHR: begin acc_we_o = 1'b1; flag_we_o = 1'b1; acc_nx_o = AW'($signed(acc_i) >>> 1); end
      OP_SHL: begin acc_we_o = 1'b1; flag_we_o = 1'b1; acc_nx_o = acc_i << 1; end
      OP_NEG: begin acc_we_o = 1'b1; flag_we_o = 1'b1; acc_nx_o = -acc_i; end
      OP_ABS: begin
        acc_we_o  = 1'b1;
        flag_we_o = 1'b1;
        acc_nx_o  = acc_i[AW-1] ? -acc_i : acc_i;
      end
      OP_MLD:  begin acc_we_o = 1'b1; xy_we_o = 1'b1; acc_nx_o = '0; end
      OP_MPYA: begin acc_we_o = 1'b1; xy_we_o = 1'b1; acc_nx_o = acc_i + prod_i; end
      OP_MPYS: begin acc_we_o = 1'b1; xy_we_o = 1'b1; acc_nx_o = acc_i - prod_i; end
      default: bad_o = 1'b1;
    endcase
  end

  always_comb begin
    if (op_i == OP_CMP) begin
      if (src_p_i) begin
        z_nx_o = (cmp_w == '0);
        n_nx_o = cmp_w[AW-1];
      end else begin
        z_nx_o = (cmp_h == '0);
        n_nx_o = cmp_h[DW-1];
      end
    end else begin
      z_nx_o = (acc_nx_o == '0);
      n_nx_o = acc_nx_o[AW-1];
    end
  end
endmodule

// File: rtl/mac_status.sv
module mac_status
  import mac_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            z_i,
  input  logic            n_i,
  output logic [ST_W-1:0] status_o
);
  logic z_q, n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q <= 1'b0;
      n_q <= 1'b0;
    end else if (we_i) begin
      z_q <= z_i;
      n_q <= n_i;
    end
  end

  generate
    for (genvar b = 0; b < ST_W; b++) begin : g_bit
      if (b == ST_Z) begin : g_z
        assign status_o[b] = z_q;
      end else if (b == ST_N) begin : g_n
        assign status_o[b] = n_q;
      end else begin : g_zero
        assign status_o[b] = 1'b0;
      end
    end
  endgenerate

  // R8: zero result can never look negative
  a_r8_z_excludes_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_q |-> !n_q);
endmodule

// File: rtl/mac_acc_core.sv
module mac_acc_core
  import mac_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter bit          SIGNED_MUL = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      op_i,
  input  logic            src_p_i,
  input  logic [DW-1:0]   opnd_i,
  input  logic [DW-1:0]   mul_a_i,
  input  logic [DW-1:0]   mul_b_i,
  output logic [2*DW-1:0] acc_o,
  output logic [DW-1:0]   x_o,
  output logic [DW-1:0]   y_o,
  output logic [2*DW-1:0] prod_o,
  output logic [ST_W-1:0] status_o,
  output logic            illegal_o
);
  localparam int unsigned AW = 2 * DW;

  mac_op_e       op;
  logic [AW-1:0] acc_q, acc_nx, prod;
  logic [DW-1:0] x_q, y_q;
  logic          acc_we, flag_we, xy_we, z_nx, n_nx, bad, bad_q;

  assign op = mac_op_e'(op_i);

  mac_product #(.DW(DW), .SIGNED_MUL(SIGNED_MUL)) u_product (
    .x_i    (x_q),
    .y_i    (y_q),
    .prod_o (prod)
  );

  mac_alu #(.DW(DW)) u_alu (
    .op_i      (op),
    .src_p_i   (src_p_i),
    .opnd_i    (opnd_i),
    .acc_i     (acc_q),
    .prod_i    (prod),
    .acc_nx_o  (acc_nx),
    .acc_we_o  (acc_we),
    .flag_we_o (flag_we),
    .xy_we_o   (xy_we),
    .z_nx_o    (z_nx),
    .n_nx_o    (n_nx),
    .bad_o     (bad)
  );

  mac_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (flag_we),
    .z_i      (z_nx),
    .n_i      (n_nx),
    .status_o (status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
      bad_q <= 1'b0;
    end else begin
      bad_q <= bad;
      if (acc_we) acc_q <= acc_nx;
      if (xy_we) begin
        x_q <= mul_a_i;
        y_q <= mul_b_i;
      end
    end
  end

  assign acc_o     = acc_q;
  assign x_o       = x_q;
  assign y_o       = y_q;
  assign prod_o    = prod;
  assign illegal_o = bad_q;

  a_r2_prod_tracks_xy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(x_o) && $stable(y_o)) |-> $stable(prod_o));

  a_r6_cmp_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |=> $stable(acc_o));

  a_r7_load_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LD) |=> $stable(status_o));

  a_r3_half_add_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD && !src_p_i) |=> (acc_o[DW-1:0] == $past(acc_o[DW-1:0])));

  a_r8_flags_follow_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHR, OP_SHL, OP_NEG, OP_ABS})
    |=> (status_o[ST_Z] == (acc_o == '0)) && (status_o[ST_N] == acc_o[AW-1]));

  a_r10_mld_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MLD) |=> (acc_o == '0) && (x_o == $past(mul_a_i)) &&
                         (y_o == $past(mul_b_i)) && $stable(status_o));

  a_r11_mpya_uses_old_p: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MPYA) |=> (acc_o == $past(acc_o) + $past(prod_o)));

  a_r12_bad_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BAD) |=> illegal_o && $stable(acc_o) && $stable(status_o) &&
                         $stable(x_o) && $stable(y_o));

  a_r12_strobe_only_on_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_BAD) |=> !illegal_o);
endmodule

// File: tb/mac_acc_core_bench.sv
module mac_acc_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic        sp = 1'b0;
  logic [15:0] d = '0, ma = '0, mb = '0;
  logic [31:0] acc, prod;
  logic [15:0] x, y, st;
  logic        ill;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_acc_core u_mac_acc_core (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .src_p_i(sp), .opnd_i(d),
    .mul_a_i(ma), .mul_b_i(mb), .acc_o(acc), .x_o(x), .y_o(y),
    .prod_o(prod), .status_o(st), .illegal_o(ill)
  );

  logic [31:0] m_acc;
  logic [15:0] m_x, m_y;
  logic        m_z, m_n, m_ill;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, a, e);
    end
  endtask

  function automatic logic [31:0] m_prod();
    longint t = longint'(m_x) * longint'(m_y) * 2;
    return t[31:0];
  endfunction

  function automatic string req_of(logic [3:0] o, bit s);
    case (o)
      4'h0, 4'hF:       return "R12";
      4'h1:             return "R7";
      4'h3:             return "R6";
      4'h2, 4'h4:       return s ? "R5" : "R3";
      4'h5, 4'h6, 4'h7: return s ? "R5" : "R4";
      4'hC:             return "R10";
      4'hD, 4'hE:       return "R11";
      default:          return "R9";
    endcase
  endfunction

  task automatic compare_all(logic [3:0] o, bit s);
    string r = req_of(o, s);
    string rs = (o inside {4'h2, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB}) ? "R8" : r;
    chk(r, "acc", acc, m_acc);
    chk(r, "x", {16'h0, x}, {16'h0, m_x});
    chk(r, "y", {16'h0, y}, {16'h0, m_y});
    chk("R2", "prod", prod, m_prod());
    chk(rs, "status", {16'h0, st}, {16'h0, m_n, 1'b0, m_z, 13'h0});
    chk("R12", "illegal", {31'h0, ill}, {31'h0, m_ill});
  endtask

  task automatic run_op(logic [3:0] o, bit s, logic [15:0] v, logic [15:0] a, logic [15:0] b);
    logic [31:0] p = m_prod();
    logic [31:0] w = s ? p : {v, 16'h0};
    logic [31:0] df;
    logic [15:0] dh;
    bit fl = 0;
    op = o; sp = s; d = v; ma = a; mb = b;
    case (o)
      4'h1: m_acc = s ? p : {v, m_acc[15:0]};
      4'h2: begin m_acc = m_acc - w; fl = 1; end
      4'h4: begin m_acc = m_acc + w; fl = 1; end
      4'h5: begin m_acc = m_acc & w; fl = 1; end
      4'h6: begin m_acc = m_acc | w; fl = 1; end
      4'h7: begin m_acc = m_acc ^ w; fl = 1; end
      4'h3: begin
        if (s) begin df = m_acc - p; m_z = (df == 0); m_n = df[31]; end
        else begin dh = m_acc[31:16] - v; m_z = (dh == 0); m_n = dh[15]; end
      end
      4'h8: begin m_acc = {m_acc[31], m_acc[31:1]}; fl = 1; end
      4'h9: begin m_acc = {m_acc[30:0], 1'b0}; fl = 1; end
      4'hA: begin m_acc = 32'h0 - m_acc; fl = 1; end
      4'hB: begin if (m_acc[31]) m_acc = 32'h0 - m_acc; fl = 1; end
      4'hC: begin m_acc = 0; m_x = a; m_y = b; end
      4'hD: begin m_acc = m_acc + p; m_x = a; m_y = b; end
      4'hE: begin m_acc = m_acc - p; m_x = a; m_y = b; end
      default: ;
    endcase
    if (fl) begin m_z = (m_acc == 0); m_n = m_acc[31]; end
    m_ill = (o == 4'hF);
    @(negedge clk);
    compare_all(o, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_acc = 0; m_x = 0; m_y = 0; m_z = 0; m_n = 0; m_ill = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "acc", acc, 0);
    chk("R1", "xy", {x, y}, 0);
    chk("R1", "status", {16'h0, st}, 0);
    chk("R1", "illegal", {31'h0, ill}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(4'hC, 0, 0, 16'h0003, 16'h0005);   // P = 30
    run_op(4'h1, 1, 0, 0, 0);                 // R7 copy P
    run_op(4'h1, 0, 16'h1234, 0, 0);          // R7 upper only
    run_op(4'h4, 0, 16'hF000, 0, 0);          // R3 carry dropped
    run_op(4'h2, 0, 16'h0235, 0, 0);          // R3 goes negative
    run_op(4'h3, 0, 16'hFFFF, 0, 0);          // R6 equal upper
    run_op(4'h3, 1, 0, 0, 0);                 // R6 vs product
    run_op(4'h6, 0, 16'h00F0, 0, 0);          // R4
    run_op(4'h7, 0, 16'h0F0F, 0, 0);          // R4
    run_op(4'h5, 0, 16'h00FF, 0, 0);          // R4 low cleared
    run_op(4'h2, 0, acc[31:16], 0, 0);        // R8 zero result
    run_op(4'h4, 1, 0, 0, 0);                 // R5
    run_op(4'h6, 1, 0, 0, 0);
    run_op(4'h7, 1, 0, 0, 0);
    run_op(4'h5, 1, 0, 0, 0);
    run_op(4'h2, 1, 0, 0, 0);
    run_op(4'hC, 0, 0, 16'hFFFF, 16'hFFFF);   // R2 large product
    run_op(4'h1, 0, 16'h8000, 0, 0);          // A = 8000_0000
    run_op(4'hB, 0, 0, 0, 0);                 // R9 abs of most negative
    run_op(4'h8, 1, 0, 0, 0);                 // R9 arithmetic shr
    run_op(4'hA, 0, 0, 0, 0);
    run_op(4'h9, 0, 0, 0, 0);
    run_op(4'hB, 0, 0, 0, 0);
    run_op(4'hD, 0, 0, 16'h1234, 16'h00FF);   // R11 old P
    run_op(4'hE, 0, 0, 16'h7FFF, 16'h8001);
    run_op(4'hF, 1, 16'hFFFF, 16'h1111, 16'h2222); // R12
    run_op(4'hF, 0, 16'h0001, 0, 0);
    run_op(4'h0, 1, 16'hABCD, 16'h3333, 16'h4444);
    run_op(4'h3, 0, 16'h0000, 0, 0);

    for (int i = 0; i < 2000; i++) begin
      logic [3:0] o = 4'($urandom_range(0, 15));
      run_op(o, 1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom), 16'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule